// File: doc/BRIEF.md
# Battery Pack Power-Mode Controller

This block decides when a battery-monitor chip may leave its active mode for a low-power sleep mode, and when it must come back. It watches the sampled level of the single-wire host bus data line. If that line stays low long enough while the power-mode enable bit is set, the block starts a sleep transition. The charge-initiation bit selects how a charge in progress is treated. With the bit clear, the charge is aborted at once. With the bit set, sleep waits until the charge has finished.

The transition passes through a bounded settling period before the chip is reported asleep. A high level on the bus wakes the chip from any non-active state. A charger being connected also wakes it, when the charge-initiation bit is set. After a wake from sleep, conversion data is flagged invalid for a fixed delay. All delays are given in milliseconds and converted at elaboration to counts of a slow timebase tick. The bus protocol and the measurements themselves are modelled only as flag and tick inputs.

Top module: `pack_pwr_mode`

## Requirements
- R1: After reset the mode status is 2'b00 (active), awake is 1, data-valid is 1 and charge-abort is 0.
- R2: While the power-mode enable input is 0, the mode status never leaves 2'b00, however long the bus stays low.
- R3: The bus-low timeout expires when the bus has been sampled low on LOW_MS/TICK_MS + 1 tick cycles since it was last high. The mode status changes on the clock edge after that. Any high bus sample restarts the count.
- R4: On a timeout with the charge-initiation bit 0, the mode status becomes 2'b01 (entering sleep). Charge-abort is high for exactly that one cycle if the charge-busy input was 1, and stays 0 otherwise.
- R5: On a timeout with the charge-initiation bit 1, the mode status becomes 2'b10 (deferred) if charge-busy is 1, or 2'b01 if it is 0. Charge-abort stays 0. From 2'b10 the status moves to 2'b01 one edge after charge-busy falls, or back to 2'b00 one edge after the enable drops.
- R6: The status 2'b01 lasts SETTLE_MS/TICK_MS tick cycles and then becomes 2'b11 (asleep). Asleep is reached only from 2'b01.
- R7: A high bus level in status 2'b01, 2'b10 or 2'b11 returns the status to 2'b00 on the next edge.
- R8: A rising edge of charger-present while the charge-initiation bit is 1 returns the status to 2'b00 on the next edge and restarts the bus-low count. With the bit 0, the same edge has no effect on the mode.
- R9: Data-valid is 0 while asleep and on the wake edge. It returns to 1 after VALID_MS/TICK_MS tick cycles.
- R10: When a charger wake and a timeout expiry fall on the same edge in status 2'b00, the wake wins. The status stays 2'b00 and a full new timeout is needed before sleep entry.
- R11: All timers advance only on cycles where the tick input is 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| tick_i | input | 1 | Timebase tick, one cycle wide, every TICK_MS |
| bus_lvl_i | input | 1 | Sampled level of the host bus data line |
| chg_present_i | input | 1 | Charger supply is present |
| mode_en_i | input | 1 | Power-mode enable configuration bit |
| cinit_i | input | 1 | Charge-initiation configuration bit |
| chg_busy_i | input | 1 | A charge is in progress |
| awake_o | output | 1 | 1 unless the status is asleep |
| mode_o | output | 2 | Mode status: 00 active, 01 entering, 10 deferred, 11 asleep |
| chg_abort_o | output | 1 | One-cycle request to stop the running charge |
| data_valid_o | output | 1 | Conversion data may be trusted |

## Verification
The bus-low timer can expire in the very cycle in which a charger rising edge raises a wake. A sleep entry and a wake then compete for the same edge. The bench holds the bus low until the expiry is registered, then raises charger-present with the charge-initiation bit set so both land on one edge. It judges the outcome by the status staying active, and by the next entry coming only a full LOW_MS/TICK_MS + 1 ticks later. A similar race between the settling countdown ending and a bus wake is covered by the checker's bus-wake property.

// File: rtl/ppm_pkg.sv
`timescale 1ns/1ps
package ppm_pkg;
   typedef enum logic [1:0] {
      ST_ACTIVE = 2'b00,
      ST_ENTER  = 2'b01,
      ST_DEFER  = 2'b10,
      ST_SLEEP  = 2'b11
   } ppm_state_e;
endpackage

// File: rtl/ppm_low_timer.sv
`timescale 1ns/1ps
// Counts ticks while the bus is low; saturates one past the limit.
module ppm_low_timer #(
   parameter int unsigned LIMIT = 200
) (
   input  logic clk,
   input  logic rst_n,
   input  logic tick_i,
   input  logic bus_lvl_i,
   input  logic clr_i,
   output logic expired_o
);
   localparam int unsigned W = $clog2(LIMIT + 2);
   localparam logic [W-1:0] SAT = W'(LIMIT + 1);

   logic [W-1:0] cnt_q;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         cnt_q <= '0;
      end else if (bus_lvl_i || clr_i) begin
         cnt_q <= '0;
      end else if (tick_i && (cnt_q != SAT)) begin
         cnt_q <= cnt_q + 1'b1;
      end
   end

   assign expired_o = (cnt_q == SAT);
endmodule

// File: rtl/ppm_countdown.sv
`timescale 1ns/1ps
// Loadable tick down-counter; done fires on the tick that ends the span.
module ppm_countdown #(
   parameter int unsigned SPAN = 11
) (
   input  logic clk,
   input  logic rst_n,
   input  logic tick_i,
   input  logic load_i,
   output logic done_o
);
   localparam int unsigned W = $clog2(SPAN + 1);
   localparam logic [W-1:0] START = W'(SPAN);
   localparam logic [W-1:0] LAST  = W'(1);

   logic [W-1:0] cnt_q;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         cnt_q <= '0;
      end else if (load_i) begin
         cnt_q <= START;
      end else if (tick_i && (cnt_q != '0)) begin
         cnt_q <= cnt_q - 1'b1;
      end
   end

   assign done_o = tick_i && !load_i && (cnt_q == LAST);
endmodule

// File: rtl/ppm_fsm.sv
`timescale 1ns/1ps
module ppm_fsm
   import ppm_pkg::*;
(
   input  logic       clk,
   input  logic       rst_n,
   input  logic       mode_en_i,
   input  logic       cinit_i,
   input  logic       chg_busy_i,
   input  logic       bus_lvl_i,
   input  logic       chg_rise_i,
   input  logic       timeout_i,
   input  logic       settle_done_i,
   input  logic       valid_done_i,
   output ppm_state_e state_o,
   output logic       abort_o,
   output logic       settle_load_o,
   output logic       valid_load_o,
   output logic       valid_o,
   output logic       chg_wake_o
);
   ppm_state_e st_q, st_d;
   logic       abort_q, abort_d;
   logic       valid_q;
   logic       wake;

   assign chg_wake_o = cinit_i && chg_rise_i;
   assign wake       = bus_lvl_i || chg_wake_o;

   always_comb begin
      st_d    = st_q;
      abort_d = 1'b0;
      unique case (st_q)
         ST_ACTIVE: begin
            if (!wake && mode_en_i && timeout_i) begin
               if (!cinit_i) begin
                  st_d    = ST_ENTER;
                  abort_d = chg_busy_i;
               end else if (chg_busy_i) begin
                  st_d = ST_DEFER;
               end else begin
                  st_d = ST_ENTER;
               end
            end
         end
         ST_DEFER: begin
            if (wake || !mode_en_i)  st_d = ST_ACTIVE;
            else if (!chg_busy_i)    st_d = ST_ENTER;
         end
         ST_ENTER: begin
            if (wake)                st_d = ST_ACTIVE;
            else if (settle_done_i)  st_d = ST_SLEEP;
         end
         ST_SLEEP: begin
            if (wake)                st_d = ST_ACTIVE;
         end
         default: st_d = ST_ACTIVE;
      endcase
   end

   assign settle_load_o = (st_d == ST_ENTER) && (st_q != ST_ENTER);
   assign valid_load_o  = (st_q == ST_SLEEP) && (st_d == ST_ACTIVE);

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         st_q    <= ST_ACTIVE;
         abort_q <= 1'b0;
         valid_q <= 1'b1;
      end else begin
         st_q    <= st_d;
         abort_q <= abort_d;
         if (st_d == ST_SLEEP || valid_load_o) valid_q <= 1'b0;
         else if (valid_done_i)                valid_q <= 1'b1;
      end
   end

   assign state_o = st_q;
   assign abort_o = abort_q;
   assign valid_o = valid_q;
endmodule

// File: rtl/pack_pwr_mode.sv
`timescale 1ns/1ps
module pack_pwr_mode
   import ppm_pkg::*;
#(
   parameter int unsigned TICK_MS   = 10,
   parameter int unsigned LOW_MS    = 2000,
   parameter int unsigned SETTLE_MS = 11000,
   parameter int unsigned VALID_MS  = 110
) (
   input  logic       clk,
   input  logic       rst_n,
   input  logic       tick_i,
   input  logic       bus_lvl_i,
   input  logic       chg_present_i,
   input  logic       mode_en_i,
   input  logic       cinit_i,
   input  logic       chg_busy_i,
   output logic       awake_o,
   output logic [1:0] mode_o,
   output logic       chg_abort_o,
   output logic       data_valid_o
);
   localparam int unsigned LOW_TICKS    = LOW_MS / TICK_MS;
   localparam int unsigned SETTLE_TICKS = SETTLE_MS / TICK_MS;
   localparam int unsigned VALID_TICKS  = VALID_MS / TICK_MS;

   generate
      if (TICK_MS == 0) begin : g_bad_tick
         $error("TICK_MS must be nonzero");
      end
      if (LOW_TICKS == 0 || SETTLE_TICKS == 0 || VALID_TICKS == 0) begin : g_bad_span
         $error("every delay must span at least one tick");
      end
      if ((LOW_MS % TICK_MS) != 0 || (SETTLE_MS % TICK_MS) != 0 ||
          (VALID_MS % TICK_MS) != 0) begin : g_bad_mult
         $error("delays must be whole multiples of TICK_MS");
      end
   endgenerate

   logic       chg_q;
   logic       chg_rise;
   logic       chg_wake;
   logic       timeout;
   logic       settle_load, settle_done;
   logic       valid_load, valid_done;
   ppm_state_e state;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) chg_q <= 1'b0;
      else        chg_q <= chg_present_i;
   end
   assign chg_rise = chg_present_i && !chg_q;

   ppm_low_timer #(.LIMIT(LOW_TICKS)) u_low (
      .clk       (clk),
      .rst_n     (rst_n),
      .tick_i    (tick_i),
      .bus_lvl_i (bus_lvl_i),
      .clr_i     (chg_wake),
      .expired_o (timeout)
   );

   ppm_countdown #(.SPAN(SETTLE_TICKS)) u_settle (
      .clk    (clk),
      .rst_n  (rst_n),
      .tick_i (tick_i),
      .load_i (settle_load),
      .done_o (settle_done)
   );

   ppm_countdown #(.SPAN(VALID_TICKS)) u_valid (
      .clk    (clk),
      .rst_n  (rst_n),
      .tick_i (tick_i),
      .load_i (valid_load),
      .done_o (valid_done)
   );

   ppm_fsm u_fsm (
      .clk           (clk),
      .rst_n         (rst_n),
      .mode_en_i     (mode_en_i),
      .cinit_i       (cinit_i),
      .chg_busy_i    (chg_busy_i),
      .bus_lvl_i     (bus_lvl_i),
      .chg_rise_i    (chg_rise),
      .timeout_i     (timeout),
      .settle_done_i (settle_done),
      .valid_done_i  (valid_done),
      .state_o       (state),
      .abort_o       (chg_abort_o),
      .settle_load_o (settle_load),
      .valid_load_o  (valid_load),
      .valid_o       (data_valid_o),
      .chg_wake_o    (chg_wake)
   );

   assign mode_o  = state;
   assign awake_o = (state != ST_SLEEP);
endmodule

// File: rtl/ppm_checker.sv
`timescale 1ns/1ps
module ppm_checker
   import ppm_pkg::*;
(
   input logic       clk,
   input logic       rst_n,
   input logic       bus_lvl_i,
   input logic       mode_en_i,
   input logic       cinit_i,
   input logic       chg_busy_i,
   input logic [1:0] mode_o,
   input logic       chg_abort_o,
   input logic       data_valid_o
);
   AST_ABORT_NEEDS_CINIT0: assert property (@(posedge clk) disable iff (!rst_n)
      chg_abort_o |-> (!$past(cinit_i) && $past(chg_busy_i))); // R4
   AST_ABORT_ONE_CYCLE: assert property (@(posedge clk) disable iff (!rst_n)
      chg_abort_o |=> !chg_abort_o); // R4
   AST_ENTRY_NEEDS_EN: assert property (@(posedge clk) disable iff (!rst_n)
      (mode_o != ST_ACTIVE && $past(mode_o) == ST_ACTIVE) |-> $past(mode_en_i)); // R2
   AST_BUS_WAKES: assert property (@(posedge clk) disable iff (!rst_n)
      (mode_o != ST_ACTIVE && bus_lvl_i) |=> (mode_o == ST_ACTIVE)); // R7
   AST_SLEEP_VIA_ENTER: assert property (@(posedge clk) disable iff (!rst_n)
      (mode_o == ST_SLEEP && $past(mode_o) != ST_SLEEP) |-> ($past(mode_o) == ST_ENTER)); // R6
   AST_WAKE_INVALID: assert property (@(posedge clk) disable iff (!rst_n)
      ($past(mode_o) == ST_SLEEP && mode_o == ST_ACTIVE) |-> !data_valid_o); // R9
   AST_ASLEEP_INVALID: assert property (@(posedge clk) disable iff (!rst_n)
      (mode_o == ST_SLEEP) |-> !data_valid_o); // R9
endmodule

bind pack_pwr_mode ppm_checker u_chk (
   .clk          (clk),
   .rst_n        (rst_n),
   .bus_lvl_i    (bus_lvl_i),
   .mode_en_i    (mode_en_i),
   .cinit_i      (cinit_i),
   .chg_busy_i   (chg_busy_i),
   .mode_o       (mode_o),
   .chg_abort_o  (chg_abort_o),
   .data_valid_o (data_valid_o)
);

// File: tb/pack_pwr_mode_test.sv
`timescale 1ns/1ps
module pack_pwr_mode_test;
   localparam int LOWT = 2000 / 10;
   localparam int SETT = 11000 / 10;
   localparam int VALT = 110 / 10;

   logic clk = 1'b0;
   logic rst_n = 1'b0;
   logic tick = 1'b1;
   logic bus = 1'b1;
   logic chg = 1'b0;
   logic men = 1'b0;
   logic cin = 1'b0;
   logic busy = 1'b0;
   logic awake, abrt, valid;
   logic [1:0] mode;

   int n_run = 0;
   int n_fail = 0;

   always #5 clk = ~clk;

   pack_pwr_mode uut (
      .clk(clk), .rst_n(rst_n), .tick_i(tick), .bus_lvl_i(bus),
      .chg_present_i(chg), .mode_en_i(men), .cinit_i(cin), .chg_busy_i(busy),
      .awake_o(awake), .mode_o(mode), .chg_abort_o(abrt), .data_valid_o(valid)
   );

   // row: {mode_en, cinit, busy, edges after bus low [11:0], exp mode [1:0], exp abort}
   localparam logic [17:0] TBL [8] = '{
      {1'b0, 1'b0, 1'b1, 12'(LOWT + 100),  2'b00, 1'b0},  // R2
      {1'b1, 1'b0, 1'b1, 12'(LOWT + 1),    2'b00, 1'b0},  // R3
      {1'b1, 1'b0, 1'b1, 12'(LOWT + 2),    2'b01, 1'b1},  // R4
      {1'b1, 1'b0, 1'b0, 12'(LOWT + 2),    2'b01, 1'b0},  // R4
      {1'b1, 1'b1, 1'b1, 12'(LOWT + 2),    2'b10, 1'b0},  // R5
      {1'b1, 1'b1, 1'b0, 12'(LOWT + 2),    2'b01, 1'b0},  // R5
      {1'b1, 1'b0, 1'b0, 12'(LOWT + 1 + SETT), 2'b01, 1'b0},  // R6
      {1'b1, 1'b0, 1'b0, 12'(LOWT + 2 + SETT), 2'b11, 1'b0}   // R6
   };
   localparam string TAG [8] = '{"R2", "R3", "R4", "R4", "R5", "R5", "R6", "R6"};

   task automatic step(input int n);
      repeat (n) @(posedge clk);
      #1;
   endtask

   task automatic check(input string req, input int act, input int exp);
      n_run++;
      if (act != exp) begin
         n_fail++;
         $display("FAIL %s: actual %0d expected %0d", req, act, exp);
      end
   endtask

   task automatic do_reset();
      #1;
      rst_n = 1'b0; bus = 1'b1; chg = 1'b0; men = 1'b0; cin = 1'b0;
      busy = 1'b0; tick = 1'b1;
      step(2);
      rst_n = 1'b1;
      step(1);
   endtask

   initial begin
      repeat (200000) @(posedge clk);
      n_fail++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
      $finish;
   end

   initial begin
      // R1 reset state
      do_reset();
      check("R1 mode", int'(mode), 0);
      check("R1 awake", int'(awake), 1);
      check("R1 valid", int'(valid), 1);
      check("R1 abort", int'(abrt), 0);

      for (int i = 0; i < 8; i++) begin
         do_reset();
         men = TBL[i][17]; cin = TBL[i][16]; busy = TBL[i][15];
         bus = 1'b0;
         step(int'(TBL[i][14:3]));
         check({TAG[i], " mode"}, int'(mode), int'(TBL[i][2:1]));
         check({TAG[i], " abort"}, int'(abrt), int'(TBL[i][0]));
      end

      // R4 abort lasts one cycle
      do_reset();
      men = 1; busy = 1; bus = 0;
      step(LOWT + 2);
      check("R4 abort high", int'(abrt), 1);
      step(1);
      check("R4 abort pulse end", int'(abrt), 0);

      // R3 high sample restarts count; R7 wake from entering
      do_reset();
      men = 1; bus = 0;
      step(150);
      bus = 1; step(1);
      bus = 0; step(LOWT + 1);
      check("R3 restart no entry", int'(mode), 0);
      step(1);
      check("R3 restart entry", int'(mode), 1);
      bus = 1; step(1);
      check("R7 wake from entering", int'(mode), 0);
      check("R7 valid kept", int'(valid), 1);

      // R5 deferred then charge ends
      do_reset();
      men = 1; cin = 1; busy = 1; bus = 0;
      step(LOWT + 2);
      check("R5 deferred", int'(mode), 2);
      busy = 0; step(1);
      check("R5 charge done enters", int'(mode), 1);

      // R5 enable dropped in deferred
      do_reset();
      men = 1; cin = 1; busy = 1; bus = 0;
      step(LOWT + 2);
      men = 0; step(1);
      check("R5 enable drop", int'(mode), 0);

      // R8/R9 charger wake from sleep, valid delay, count restart
      do_reset();
      men = 1; cin = 1; bus = 0;
      step(LOWT + 2 + SETT);
      check("R9 asleep mode", int'(mode), 3);
      check("R9 asleep awake", int'(awake), 0);
      check("R9 asleep valid", int'(valid), 0);
      chg = 1; step(1);
      check("R8 charger wake", int'(mode), 0);
      check("R9 valid at wake", int'(valid), 0);
      step(VALT - 1);
      check("R9 valid still low", int'(valid), 0);
      step(1);
      check("R9 valid restored", int'(valid), 1);
      step(LOWT + 1 - VALT);
      check("R8 count restarted", int'(mode), 0);
      step(1);
      check("R8 re-entry", int'(mode), 1);

      // R8 charger ignored with cinit 0; R7 bus wake from sleep
      do_reset();
      men = 1; bus = 0;
      step(LOWT + 2 + SETT);
      chg = 1; step(3);
      check("R8 no wake cinit0", int'(mode), 3);
      bus = 1; step(1);
      check("R7 bus wake from sleep", int'(mode), 0);

      // R10 wake and expiry on one edge
      do_reset();
      men = 1; cin = 1; bus = 0;
      step(LOWT + 1);
      chg = 1; step(1);
      check("R10 wake wins", int'(mode), 0);
      step(LOWT + 1);
      check("R10 full new timeout", int'(mode), 0);
      step(1);
      check("R10 later entry", int'(mode), 1);

      // R11 no ticks, no progress
      do_reset();
      men = 1; tick = 0; bus = 0;
      step(500);
      check("R11 frozen", int'(mode), 0);
      tick = 1;
      step(LOWT + 2);
      check("R11 resumes", int'(mode), 1);

      $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
      $finish;
   end
endmodule